// File: doc/BRIEF.md
# DRAM refresh and initialization sequencer

This block brings a 1024-row asynchronous DRAM out of power-up and keeps it refreshed afterwards. After reset it holds off for a configurable settling pause and then runs a fixed number of CAS-before-RAS (CBR) refresh cycles. Only after those cycles does it raise a sticky ready flag for the rest of the system. From then on, an interval timer derived from the refresh period and the row count marks when one more row refresh is owed. The device's own row counter supplies the row address, so the block drives no address.

The block never takes the memory strobes without permission. It raises a request toward the access controller and waits for a grant. Once the grant arrives, it owns RAS and CAS until every owed cycle has run, and then it drops the request. If the controller holds the grant back, expired intervals pile up to a small cap and are then run back to back. All pulse widths are expressed in nanoseconds and converted to clock cycles from a clock-period parameter.

The request/grant pair is a plain level handshake and carries no data. The controller may keep the grant high or low at any time. The block only looks at the grant while it is requesting. After a grant has been seen, a later drop of the grant does not stop a refresh burst that is already running.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset is released, `refresh_req` stays low and `ras_n`/`cas_n` stay high for PAUSE_CYC = ceil(PAUSE_NS*1000/CLK_PS) clocks. The first request appears on the clock after that pause.
- R2: After the pause, exactly INIT_CYCLES CBR cycles run before `mem_ready` rises. Once high, `mem_ready` never falls until reset.
- R3: Every cycle is CAS-before-RAS. `cas_n` falls exactly CSR_CYC clocks before `ras_n` falls, and it rises exactly CHR_CYC clocks after `ras_n` fell.
- R4: `ras_n` stays low exactly RASL_CYC clocks per cycle. Consecutive RAS falling edges are at least RC_CYC clocks apart.
- R5: Before `cas_n` falls, both strobes have been high for at least PRE_CYC+1 clocks, where PRE_CYC = max(RASH_CYC, CPN_CYC, RPC_CYC, RC_CYC-RASL_CYC). This covers the CAS-high and RAS-to-CAS precharge minimums.
- R6: Once ready, one refresh is owed every INT_CYC = floor((REFRESH_NS/ROWS)*1000/CLK_PS) clocks. When the grant follows the request with no delay, consecutive RAS falls are exactly INT_CYC clocks apart.
- R7: The strobes go low only after a grant has been seen while `refresh_req` is high. The request stays high until all owed cycles are finished. A grant that arrives while the request is low has no effect.
- R8: While the grant is withheld, owed refreshes accumulate up to PEND_MAX, and further expirations are dropped. When the grant comes, exactly that many cycles run, each CAS fall following the previous RAS rise by PRE_CYC+1 clocks.
- R9: `we_n` is high at all times, so no write-qualified CBR (test-mode entry) cycle is ever issued.
- R10: During reset, `refresh_req`=0, `ras_n`=1, `cas_n`=1, `mem_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_PS picoseconds |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_req | output | 1 | High while the block wants or holds the memory strobes |
| refresh_gnt | input | 1 | Controller permission; sampled only while requesting |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM, active low |
| we_n | output | 1 | Write enable to the DRAM, held high |
| mem_ready | output | 1 | High once power-up pause and initial cycles are done |

## Verification
The bench measures each strobe edge in clock counts and compares it against the cycle counts derived from the timing parameters. If CAS rose too early or RAS were released short, the exact-distance checks would report it. Grant-withholding runs show whether owed refreshes are capped and replayed as a tight burst. A counter that wrapped or that lost refreshes would give the wrong burst length. A grant held high while nothing is owed must produce no strobe activity and no request, and would expose a design that acts on the grant alone. Interval spacing with an immediate grant pins the timer period, and randomized grant delays check that strobes never move before permission.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [1:0] {
    SEQ_PAUSE,
    SEQ_IDLE,
    SEQ_ASK,
    SEQ_OWN
  } seq_state_t;

  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_CAS_LEAD,
    CYC_RAS_LOW,
    CYC_PRECHG
  } cyc_state_t;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int ns_to_cyc_up(input longint ns, input longint clk_ps);
    longint c;
    c = (ns * 64'sd1000 + clk_ps - 64'sd1) / clk_ps;
    if (c < 64'sd1) c = 64'sd1;
    return int'(c);
  endfunction

  // nanoseconds to clock cycles, rounded down, never below two
  function automatic int ns_to_cyc_down(input longint ns, input longint clk_ps);
    longint c;
    c = (ns * 64'sd1000) / clk_ps;
    if (c < 64'sd2) c = 64'sd2;
    return int'(c);
  endfunction

  function automatic int max_of2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_interval_timer.sv
module dram_interval_timer #(
  parameter int INTERVAL_CYC = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int TW = $clog2(INTERVAL_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == LAST);

  generate
    if (INTERVAL_CYC > 1) begin : g_spacing
      assert_tick_spaced_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/dram_owed_counter.sv
module dram_owed_counter #(
  parameter int PEND_MAX = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic add,
  input  logic take,
  output logic [$clog2(PEND_MAX+1)-1:0] owed
);
  localparam int PW = $clog2(PEND_MAX + 1);
  localparam logic [PW-1:0] CAP = PW'(PEND_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed <= '0;
    end else begin
      unique case ({add, take})
        2'b10:   if (owed != CAP) owed <= owed + 1'b1;
        2'b01:   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  assert_owed_capped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= CAP);
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> owed != '0);

endmodule

// File: rtl/dram_cbr_engine.sv
module dram_cbr_engine
  import dram_refresh_pkg::*;
#(
  parameter int CSR_CYC  = 2,
  parameter int CHR_CYC  = 2,
  parameter int RASL_CYC = 12,
  parameter int PRE_CYC  = 10,
  parameter int CPN_CYC  = 2,
  parameter int RPC_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ras_n,
  output logic cas_n,
  output logic idle,
  output logic done
);
  localparam int LONGEST = max_of2(max_of2(CSR_CYC, RASL_CYC), PRE_CYC);
  localparam int CW = $clog2(LONGEST + 1);
  localparam logic [CW-1:0] CSR_LAST  = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] RASL_LAST = CW'(RASL_CYC - 1);
  localparam logic [CW-1:0] PRE_LAST  = CW'(PRE_CYC - 1);
  localparam logic [CW-1:0] CAS_UP_AT = CW'((RASL_CYC > CHR_CYC) ? (RASL_CYC - CHR_CYC) : 0);

  cyc_state_t    st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= CYC_IDLE;
      cnt   <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
    end else begin
      unique case (st)
        CYC_IDLE: begin
          if (start) begin
            cas_n <= 1'b0;
            cnt   <= CSR_LAST;
            st    <= CYC_CAS_LEAD;
          end
        end
        CYC_CAS_LEAD: begin
          if (cnt == '0) begin
            ras_n <= 1'b0;
            cnt   <= RASL_LAST;
            st    <= CYC_RAS_LOW;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        CYC_RAS_LOW: begin
          if (cnt == CAS_UP_AT) cas_n <= 1'b1;
          if (cnt == '0) begin
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            cnt   <= PRE_LAST;
            st    <= CYC_PRECHG;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        CYC_PRECHG: begin
          if (cnt == '0) st <= CYC_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= CYC_IDLE;
      endcase
    end
  end

  assign idle = (st == CYC_IDLE);
  assign done = (st == CYC_PRECHG) && (cnt == '0);

  // Strobe run-length monitors feeding the timing assertions
  localparam int MW = CW + 2;
  logic [MW-1:0] ras_lo_run, ras_hi_run, cas_lo_run, cas_hi_run;

  function automatic logic [MW-1:0] sat_up(input logic [MW-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_lo_run <= '0;
      cas_lo_run <= '0;
      ras_hi_run <= '1;
      cas_hi_run <= '1;
    end else begin
      ras_lo_run <= ras_n ? '0 : sat_up(ras_lo_run);
      ras_hi_run <= ras_n ? sat_up(ras_hi_run) : '0;
      cas_lo_run <= cas_n ? '0 : sat_up(cas_lo_run);
      cas_hi_run <= cas_n ? sat_up(cas_hi_run) : '0;
    end
  end

  assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && cas_lo_run >= MW'(CSR_CYC)));
  assert_cas_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> ras_lo_run >= MW'(CHR_CYC));
  assert_ras_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> ras_lo_run >= MW'(RASL_CYC));
  assert_ras_prechg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> (ras_n && ras_hi_run >= MW'(RPC_CYC)));
  assert_cas_prechg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> cas_hi_run >= MW'(CPN_CYC));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_refresh_pkg::*;
#(
  parameter int CLK_PS      = 5000,
  parameter int PAUSE_NS    = 100000,
  parameter int INIT_CYCLES = 8,
  parameter int ROWS        = 1024,
  parameter int REFRESH_NS  = 16000000,
  parameter int PEND_MAX    = 3,
  parameter int T_CSR_NS    = 10,
  parameter int T_CHR_NS    = 10,
  parameter int T_RASL_NS   = 60,
  parameter int T_RASH_NS   = 40,
  parameter int T_RC_NS     = 110,
  parameter int T_CPN_NS    = 10,
  parameter int T_RPC_NS    = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic refresh_req,
  input  logic refresh_gnt,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic mem_ready
);
  localparam int PAUSE_CYC = ns_to_cyc_up(longint'(PAUSE_NS), longint'(CLK_PS));
  localparam int CSR_CYC   = ns_to_cyc_up(longint'(T_CSR_NS), longint'(CLK_PS));
  localparam int CHR_CYC   = ns_to_cyc_up(longint'(T_CHR_NS), longint'(CLK_PS));
  localparam int RASL_CYC  = ns_to_cyc_up(longint'(T_RASL_NS), longint'(CLK_PS));
  localparam int RASH_CYC  = ns_to_cyc_up(longint'(T_RASH_NS), longint'(CLK_PS));
  localparam int RC_CYC    = ns_to_cyc_up(longint'(T_RC_NS), longint'(CLK_PS));
  localparam int CPN_CYC   = ns_to_cyc_up(longint'(T_CPN_NS), longint'(CLK_PS));
  localparam int RPC_CYC   = ns_to_cyc_up(longint'(T_RPC_NS), longint'(CLK_PS));
  localparam int RC_REST   = (RC_CYC > RASL_CYC) ? (RC_CYC - RASL_CYC) : 1;
  localparam int PRE_CYC   = max_of2(max_of2(RASH_CYC, RC_REST), max_of2(CPN_CYC, RPC_CYC));
  localparam int INT_CYC   = ns_to_cyc_down(longint'(REFRESH_NS / ROWS), longint'(CLK_PS));

  localparam int PCW = $clog2(PAUSE_CYC + 1);
  localparam logic [PCW-1:0] PAUSE_LAST = PCW'(PAUSE_CYC - 1);
  localparam int IW = $clog2(INIT_CYCLES + 1);
  localparam int PW = $clog2(PEND_MAX + 1);

  seq_state_t     st;
  logic [PCW-1:0] pause_cnt;
  logic [IW-1:0]  init_left;
  logic [PW-1:0]  owed;
  logic           tick, eng_idle, eng_done, owed_any, start;

  assign owed_any = mem_ready ? (owed != '0) : (init_left != '0);
  assign start    = (st == SEQ_OWN) && eng_idle && owed_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SEQ_PAUSE;
      pause_cnt <= '0;
      init_left <= IW'(INIT_CYCLES);
      mem_ready <= 1'b0;
    end else begin
      unique case (st)
        SEQ_PAUSE: begin
          if (pause_cnt == PAUSE_LAST) st <= SEQ_ASK;
          else                         pause_cnt <= pause_cnt + 1'b1;
        end
        SEQ_IDLE: if (owed_any)        st <= SEQ_ASK;
        SEQ_ASK:  if (refresh_gnt)     st <= SEQ_OWN;
        SEQ_OWN:  if (eng_idle && !owed_any) st <= SEQ_IDLE;
        default:  st <= SEQ_IDLE;
      endcase
      if (start && !mem_ready) init_left <= init_left - 1'b1;
      if (eng_done && !mem_ready && init_left == '0) mem_ready <= 1'b1;
    end
  end

  assign refresh_req = (st == SEQ_ASK) || (st == SEQ_OWN);
  assign we_n        = 1'b1;

  dram_interval_timer #(.INTERVAL_CYC(INT_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (mem_ready),
    .tick (tick)
  );

  dram_owed_counter #(.PEND_MAX(PEND_MAX)) u_owed (
    .clk  (clk),
    .rst_n(rst_n),
    .add  (tick),
    .take (start && mem_ready),
    .owed (owed)
  );

  dram_cbr_engine #(
    .CSR_CYC (CSR_CYC),
    .CHR_CYC (CHR_CYC),
    .RASL_CYC(RASL_CYC),
    .PRE_CYC (PRE_CYC),
    .CPN_CYC (CPN_CYC),
    .RPC_CYC (RPC_CYC)
  ) u_engine (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .idle (eng_idle),
    .done (eng_done)
  );

  assert_strobe_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> refresh_req);
  assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready |=> mem_ready);
  assert_quiet_in_pause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SEQ_PAUSE) |-> (ras_n && cas_n && !refresh_req));

endmodule

// File: tb/sim_dram_refresh_seq.sv
`timescale 1ns/1ps
module sim_dram_refresh_seq;
  localparam int CLK_PS      = 5000;
  localparam int PAUSE_NS    = 2000;
  localparam int INIT_CYCLES = 8;
  localparam int ROWS        = 1024;
  localparam int REFRESH_NS  = 1024 * 2000;
  localparam int PEND_MAX    = 3;

  function automatic int up_cyc(input int ns);
    return (ns * 1000 + CLK_PS - 1) / CLK_PS;
  endfunction

  localparam int PAUSE_CYC = (PAUSE_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int CSR_CYC   = 2;   // 10 ns at 5 ns clock
  localparam int CHR_CYC   = 2;
  localparam int RASL_CYC  = 12;  // 60 ns
  localparam int RC_CYC    = 22;  // 110 ns
  localparam int PRE_CYC   = 10;  // max(8, 2, 2, 22-12)
  localparam int INT_CYC   = ((REFRESH_NS / ROWS) * 1000) / CLK_PS;
  localparam int WD_LIMIT  = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic refresh_gnt = 1'b0;
  logic refresh_req, ras_n, cas_n, we_n, mem_ready;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(
    .CLK_PS(CLK_PS), .PAUSE_NS(PAUSE_NS), .INIT_CYCLES(INIT_CYCLES),
    .ROWS(ROWS), .REFRESH_NS(REFRESH_NS), .PEND_MAX(PEND_MAX)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .refresh_req(refresh_req), .refresh_gnt(refresh_gnt),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .mem_ready(mem_ready)
  );

  int checks = 0, fails = 0;
  int cyc = 0, first_req_cyc = -1, rf_count = 0;
  int t_cf = 0, t_rf = 0, t_rr = -100000, last_gap = 0;
  int act_bad = 0, we_bad = 0, gdelay = 0, gmode = 0;
  bit prev_ras = 1, prev_cas = 1, prev_ready = 0, prev_req = 0, granted = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #0.1;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // monitor and grant driver
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cyc++;
      if (we_n !== 1'b1) we_bad++;
      if (refresh_req && first_req_cyc < 0) first_req_cyc = cyc;
      granted = refresh_req && (granted || (prev_req && refresh_gnt));
      if ((!ras_n || !cas_n) && !granted) act_bad++;
      if (prev_cas && !cas_n) begin
        last_gap = cyc - t_rr;
        chk(last_gap >= PRE_CYC + 1, "R5 precharge before CAS fall", last_gap, PRE_CYC + 1);
        t_cf = cyc;
      end
      if (prev_ras && !ras_n) begin
        chk(!cas_n && (cyc - t_cf == CSR_CYC), "R3 CAS lead", cyc - t_cf, CSR_CYC);
        if (rf_count > 0) chk(cyc - t_rf >= RC_CYC, "R4 cycle time", cyc - t_rf, RC_CYC);
        t_rf = cyc;
        rf_count++;
      end
      if (!prev_cas && cas_n) chk(cyc - t_rf == CHR_CYC, "R3 CAS hold", cyc - t_rf, CHR_CYC);
      if (!prev_ras && ras_n) begin
        chk(cyc - t_rf == RASL_CYC, "R4 RAS width", cyc - t_rf, RASL_CYC);
        t_rr = cyc;
      end
      if (mem_ready && !prev_ready)
        chk(rf_count == INIT_CYCLES && ras_n && cas_n, "R2 init count at ready", rf_count, INIT_CYCLES);
      if (!mem_ready && prev_ready) chk(0, "R2 ready dropped", 0, 1);
      prev_ras = ras_n; prev_cas = cas_n; prev_ready = mem_ready; prev_req = refresh_req;
      case (gmode)
        0: refresh_gnt = refresh_req;
        1: refresh_gnt = 1'b0;
        3: refresh_gnt = 1'b1;
        default: begin
          if (!refresh_req) begin
            refresh_gnt = 1'b0;
            gdelay = $urandom % 61;
          end else if (!refresh_gnt) begin
            if (gdelay == 0) refresh_gnt = 1'b1;
            else gdelay--;
          end
        end
      endcase
      if (cyc > WD_LIMIT) begin
        fails++;
        checks++;
        $display("FAIL watchdog all requirements actual=%0d expected<=%0d", cyc, WD_LIMIT);
        finish_run();
      end
    end
  end

  initial begin
    int base, prev_t, got;
    void'($urandom(32'd4242));
    repeat (3) step();
    // R10: reset state
    chk(!refresh_req && ras_n && cas_n && !mem_ready && we_n, "R10 reset outputs",
        {refresh_req, ras_n, cas_n, mem_ready}, 4'b0110);
    rst_n = 1'b1;
    // R1: power-up pause
    while (first_req_cyc < 0) step();
    chk(first_req_cyc >= PAUSE_CYC && first_req_cyc <= PAUSE_CYC + 1, "R1 pause length",
        first_req_cyc, PAUSE_CYC);
    chk(rf_count == 0, "R1 no strobes during pause", rf_count, 0);
    // R2: initial cycles then ready
    while (!mem_ready) step();
    chk(rf_count == INIT_CYCLES, "R2 cycles before ready", rf_count, INIT_CYCLES);
    // R6: spacing with immediate grant
    base = rf_count;
    while (rf_count < base + 1) step();
    prev_t = t_rf;
    for (int k = 0; k < 3; k++) begin
      base = rf_count;
      while (rf_count < base + 1) step();
      chk(t_rf - prev_t == INT_CYC, "R6 refresh spacing", t_rf - prev_t, INT_CYC);
      prev_t = t_rf;
    end
    // R7: grant while nothing is owed
    while (refresh_req) step();
    gmode = 3;
    base = rf_count;
    repeat (INT_CYC / 2) step();
    chk(rf_count == base && !refresh_req, "R7 idle grant ignored", rf_count - base, 0);
    gmode = 0;
    // R8: withheld grant, capped backlog
    base = rf_count;
    while (rf_count < base + 1) step();
    while (refresh_req) step();
    gmode = 1;
    base = rf_count;
    repeat (5 * INT_CYC) step();
    chk(refresh_req, "R7 request held awaiting grant", refresh_req, 1);
    chk(rf_count == base, "R7 no strobes without grant", rf_count - base, 0);
    gmode = 0;
    step();
    while (refresh_req) step();
    chk(rf_count - base == PEND_MAX, "R8 burst length", rf_count - base, PEND_MAX);
    chk(last_gap == PRE_CYC + 1, "R8 back-to-back gap", last_gap, PRE_CYC + 1);
    // R6/R7: random grant latency
    gmode = 2;
    base = rf_count;
    repeat (20 * INT_CYC) step();
    got = rf_count - base;
    chk(got >= 19 && got <= 21, "R6 refresh count under random grant", got, 20);
    gmode = 0;
    step();
    while (refresh_req) step();
    chk(mem_ready, "R2 ready stays high", mem_ready, 1);
    chk(act_bad == 0, "R7 strobes only after grant", act_bad, 0);
    chk(we_bad == 0, "R9 write enable held high", we_bad, 0);
    finish_run();
  end

endmodule